// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block produces the system reset of a processor supervisor from three digital flags: a supply-good indication from an external threshold comparator, an active-low manual reset request, and a power-fail comparator result. Reset is held through the block's own power-on, through any loss of supply-good, and through a qualified manual reset. Once every cause has cleared, reset stays on for a further release timeout and only then lets go.

The manual reset request is filtered: a low level must persist for a minimum number of clock cycles before it counts, so contact bounce and short glitches are discarded. Supply recovery and manual-reset release share one release timer, and a cause that returns during the countdown restarts it. Two registered reset outputs of opposite polarity are provided. The power-fail flag is passed straight through to its own output. A watchdog has no input here; its output reaches reset only when it is wired onto the manual reset input.

Every duration is a count of the system clock: `TIMEOUT` for the release period (nominally 200 ms, with 140 ms to 260 ms acceptable) and `MR_MIN` for the manual reset qualification width (nominally 550 ns).

Top module: `supv_reset_seq`

## Requirements
- R1: While `rst` is high, and after it falls until the release condition of R2 is met, `reset_hi_o` is 1 and `reset_lo_n_o` is 0.
- R2: When `supply_ok_i` is sampled high at rising edge 1 and stays high with no manual reset active, the reset outputs release after rising edge TIMEOUT+2. After edge TIMEOUT+1 they are still asserted.
- R3: A low sample of `supply_ok_i` at rising edge 1 asserts reset after edge 3, even if the low lasts for only one sample. The release timeout then restarts from zero and follows R2 from the first high sample afterwards.
- R4: A low on `mr_n_i` that lasts fewer than MR_MIN consecutive rising-edge samples has no effect on the reset outputs.
- R5: When `mr_n_i` is first sampled low at rising edge 1 and stays low, reset asserts after edge MR_MIN+3 and not earlier.
- R6: After a qualified manual reset, when `mr_n_i` is first sampled high at rising edge 1, reset stays asserted through edge TIMEOUT+2 and releases after edge TIMEOUT+3.
- R7: `reset_lo_n_o` is the exact complement of `reset_hi_o` in every cycle, with the active-high output at 1 while reset is asserted.
- R8: `pf_o` equals `pf_flag_i` at all times, with no register, delay or stretching, and it is independent of the reset state.
- R9: If any cause becomes active again while the release timeout is counting, the count clears. The release is then timed from the last cause to clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all durations are counted in its cycles |
| rst | input | 1 | Synchronous active-high reset; models the block's own power-on state |
| supply_ok_i | input | 1 | Supply-good flag from the threshold comparator, asynchronous |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| pf_flag_i | input | 1 | Power-fail comparator result, 1 when the monitored input is above threshold |
| reset_hi_o | output | 1 | System reset, active high, registered |
| reset_lo_n_o | output | 1 | System reset, active low, registered |
| pf_o | output | 1 | Power-fail output, a direct copy of `pf_flag_i` |

## Verification
A release counter that is corrupted or cleared at the wrong moment appears on the reset outputs as a release one or more cycles early or late. The cycle-exact checks at the R2, R3, R6 and R9 boundaries catch this at the release edge itself. A fault in the manual-reset filter shows up at MR_MIN+3 cycles as either a missing assertion or a spurious one after a short pulse. A polarity or complement fault shows up in the first cycle after reset. The random phase compares every cycle against a model built from the stated latencies, so a wrong state is reported in the cycle it first reaches a port.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Release timer phases.
  typedef enum logic [1:0] {
    TMR_HOLD  = 2'd0,  // a cause is active, count held at zero
    TMR_COUNT = 2'd1,  // all causes clear, counting towards release
    TMR_OPEN  = 2'd2   // reset released
  } tmr_state_e;

  // Width needed to hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= RST_VAL;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int unsigned MR_MIN = 55
) (
  input  logic clk,
  input  logic rst,
  input  logic mr_n_s,   // synchronised request, active low
  output logic mr_q      // qualified manual reset, active high
);

  import supv_pkg::*;

  localparam int unsigned RW = cnt_width(MR_MIN);
  localparam logic [RW-1:0] LIM = RW'(MR_MIN - 1);

  logic [RW-1:0] run_q, run_n;
  logic          qual_n;

  // run_q holds how many low samples preceded the current one (saturating).
  always_comb begin
    if (mr_n_s) begin
      run_n  = '0;
      qual_n = 1'b0;
    end else begin
      run_n  = (run_q >= LIM) ? run_q : run_q + 1'b1;
      qual_n = (run_q >= LIM);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      mr_q  <= 1'b0;
    end else begin
      run_q <= run_n;
      mr_q  <= qual_n;
    end
  end

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int unsigned TIMEOUT = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,        // any reset cause active this cycle
  output logic rst_hi_q,
  output logic rst_lo_n_q
);

  import supv_pkg::*;

  localparam int unsigned CW = cnt_width(TIMEOUT);
  localparam logic [CW-1:0] TLIM = CW'(TIMEOUT);

  tmr_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (cause) begin
      st_n  = TMR_HOLD;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        TMR_HOLD, TMR_COUNT: begin
          if (cnt_inc >= TLIM) begin
            st_n  = TMR_OPEN;
            cnt_n = '0;
          end else begin
            st_n  = TMR_COUNT;
            cnt_n = cnt_inc;
          end
        end
        default: begin
          st_n  = TMR_OPEN;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= TMR_HOLD;
      cnt_q      <= '0;
      rst_hi_q   <= 1'b1;
      rst_lo_n_q <= 1'b0;
    end else begin
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      rst_hi_q   <= (st_n != TMR_OPEN);
      rst_lo_n_q <= (st_n == TMR_OPEN);
    end
  end

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
  parameter int unsigned TIMEOUT     = 20_000_000,  // 200 ms at 100 MHz
  parameter int unsigned MR_MIN      = 55,          // 550 ns at 100 MHz
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  input  logic pf_flag_i,
  output logic reset_hi_o,
  output logic reset_lo_n_o,
  output logic pf_o
);

  logic ok_s;
  logic mr_s_n;
  logic mr_q;
  logic cause;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ok (
    .clk(clk), .rst(rst), .d(supply_ok_i), .q(ok_s)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mr (
    .clk(clk), .rst(rst), .d(mr_n_i), .q(mr_s_n)
  );

  supv_mr_filter #(.MR_MIN(MR_MIN)) u_mr (
    .clk(clk), .rst(rst), .mr_n_s(mr_s_n), .mr_q(mr_q)
  );

  assign cause = ~ok_s | mr_q;

  supv_hold_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst(rst), .cause(cause),
    .rst_hi_q(reset_hi_o), .rst_lo_n_q(reset_lo_n_o)
  );

  // Power-fail output is a straight pass-through of the comparator flag.
  assign pf_o = pf_flag_i;

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int unsigned TIMEOUT = 20_000_000,
  parameter int unsigned MR_MIN  = 55
) (
  input logic clk,
  input logic rst,
  input logic supply_ok_i,
  input logic reset_hi_o,
  input logic reset_lo_n_o,
  input logic cause,
  input logic mr_s_n,
  input logic mr_q
);

  localparam int unsigned CW = supv_pkg::cnt_width(TIMEOUT);
  localparam int unsigned RW = supv_pkg::cnt_width(MR_MIN);

  logic [2:0]    cyc;
  logic [CW-1:0] crun;
  logic [RW-1:0] lrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= '0;
      crun <= '0;
      lrun <= '0;
    end else begin
      if (cyc != 3'd7) cyc <= cyc + 1'b1;
      if (cause) crun <= '0;
      else if (crun != CW'(TIMEOUT)) crun <= crun + 1'b1;
      if (mr_s_n) lrun <= '0;
      else if (lrun != RW'(MR_MIN)) lrun <= lrun + 1'b1;
    end
  end

  // R1: reset state drives the asserted pair
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (reset_hi_o && !reset_lo_n_o));

  // R2: release only after TIMEOUT clear cycles
  a_r2_release_time: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_hi_o) |-> (crun == CW'(TIMEOUT)));

  // R3: a supply-low sample asserts reset three edges later
  a_r3_supply_drop: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && !$past(supply_ok_i, 3)) |-> reset_hi_o);

  // R5: qualification needs MR_MIN consecutive low samples
  a_r5_mr_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mr_q) |-> (lrun == RW'(MR_MIN)));

  // R7: outputs are complements
  a_r7_complement: assert property (@(posedge clk) disable iff (rst)
    reset_hi_o != reset_lo_n_o);

  // R9: any active cause holds reset on the next cycle
  a_r9_cause_holds: assert property (@(posedge clk) disable iff (rst)
    cause |=> reset_hi_o);

endmodule

bind supv_reset_seq supv_reset_chk #(.TIMEOUT(TIMEOUT), .MR_MIN(MR_MIN)) u_chk (
  .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i),
  .reset_hi_o(reset_hi_o), .reset_lo_n_o(reset_lo_n_o),
  .cause(cause), .mr_s_n(mr_s_n), .mr_q(mr_q)
);

// File: tb/tb_supv_reset_seq.sv
module tb_supv_reset_seq;

  localparam int T  = 20;
  localparam int MR = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok_i = 1'b0;
  logic mr_n_i = 1'b1;
  logic pf_flag_i = 1'b0;
  logic reset_hi_o, reset_lo_n_o, pf_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  supv_reset_seq #(.TIMEOUT(T), .MR_MIN(MR), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i), .mr_n_i(mr_n_i),
    .pf_flag_i(pf_flag_i), .reset_hi_o(reset_hi_o),
    .reset_lo_n_o(reset_lo_n_o), .pf_o(pf_o)
  );

  // Reference model built from the stated latencies (R2, R3, R5, R6, R9).
  logic [1:0] h_ok, h_mr;
  int m_run, m_clear;
  logic m_q, m_as;

  always @(posedge clk) begin
    if (rst) begin
      h_ok <= 2'b00; h_mr <= 2'b11;
      m_run <= 0; m_q <= 1'b0; m_clear <= 0; m_as <= 1'b1;
    end else begin
      h_ok <= {h_ok[0], supply_ok_i};
      h_mr <= {h_mr[0], mr_n_i};
      if (h_mr[1]) begin m_run <= 0; m_q <= 1'b0; end
      else begin m_run <= m_run + 1; m_q <= (m_run + 1 >= MR); end
      if (!h_ok[1] || m_q) begin m_clear <= 0; m_as <= 1'b1; end
      else begin
        m_clear <= m_clear + 1;
        if (m_clear + 1 >= T) m_as <= 1'b0;
      end
    end
  end

  function automatic bit exp_lo_n(input bit asserted);
    return !asserted;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the clock edge.
  always begin
    @(posedge clk); #3;
    if (!rst && !done) begin
      chk({tag, "/model"}, reset_hi_o, m_as);
      chk("R7", reset_lo_n_o, exp_lo_n(m_as));
      chk("R8", pf_o, pf_flag_i);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic drv_ok(input logic v);
    @(negedge clk); supply_ok_i = v;
  endtask

  task automatic drv_mr(input logic v);
    @(negedge clk); mr_n_i = v;
  endtask

  initial begin
    int ok_low;
    int mr_low;
    ok_low = 0; mr_low = 0;
    void'($urandom(32'd4242));

    // R1: reset state
    step(3);
    chk("R1", reset_hi_o, 1'b1);
    chk("R1", reset_lo_n_o, 1'b0);
    @(negedge clk); rst = 1'b0;
    step(10);
    chk("R1", reset_hi_o, 1'b1);

    // R2: exact release after supply good
    tag = "R2";
    drv_ok(1'b1);
    step(T + 1);
    chk("R2", reset_hi_o, 1'b1);
    step(1);
    chk("R2", reset_hi_o, 1'b0);
    chk("R7", reset_lo_n_o, 1'b1);

    // R8: pass-through regardless of reset state
    @(negedge clk); pf_flag_i = 1'b1; #1;
    chk("R8", pf_o, 1'b1);

    // R3: supply drop asserts after the 3rd edge, then full restart
    tag = "R3";
    drv_ok(1'b0);
    step(2);
    chk("R3", reset_hi_o, 1'b0);
    step(1);
    chk("R3", reset_hi_o, 1'b1);
    @(negedge clk); pf_flag_i = 1'b0; #1;
    chk("R8", pf_o, 1'b0);
    drv_ok(1'b1);
    step(T / 2);
    drv_ok(1'b0);       // one-sample glitch
    drv_ok(1'b1);
    step(T + 1);
    chk("R3", reset_hi_o, 1'b1);
    step(1);
    chk("R3", reset_hi_o, 1'b0);

    // R4: short manual pulse is ignored
    tag = "R4";
    drv_mr(1'b0);
    repeat (MR - 2) @(negedge clk);
    mr_n_i = 1'b1;
    step(MR + 6);
    chk("R4", reset_hi_o, 1'b0);

    // R5: qualified manual reset timing
    tag = "R5";
    drv_mr(1'b0);
    step(MR + 2);
    chk("R5", reset_hi_o, 1'b0);
    step(1);
    chk("R5", reset_hi_o, 1'b1);
    step(4);

    // R6: release after manual reset ends
    tag = "R6";
    drv_mr(1'b1);
    step(T + 2);
    chk("R6", reset_hi_o, 1'b1);
    step(1);
    chk("R6", reset_hi_o, 1'b0);

    // R9: manual reset during supply countdown; timed from the later cause
    tag = "R9";
    drv_ok(1'b0);
    drv_ok(1'b1);
    step(T / 2);
    drv_mr(1'b0);
    repeat (MR + 3) @(negedge clk);
    mr_n_i = 1'b1;
    step(T + 2);
    chk("R9", reset_hi_o, 1'b1);
    step(1);
    chk("R9", reset_hi_o, 1'b0);

    // Random phase, checked each cycle against the model
    tag = "R2R3R4R5R6R9";
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) pf_flag_i = ~pf_flag_i;
      if (ok_low == 0 && $urandom_range(0, 299) == 0) ok_low = $urandom_range(1, 40);
      supply_ok_i = (ok_low == 0);
      if (ok_low > 0) ok_low--;
      if (mr_low == 0 && $urandom_range(0, 149) == 0) mr_low = $urandom_range(1, 3 * MR);
      mr_n_i = (mr_low == 0);
      if (mr_low > 0) mr_low--;
    end
    supply_ok_i = 1'b1; mr_n_i = 1'b1;
    step(T + 10);
    chk("R2", reset_hi_o, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule